// File: doc/BRIEF.md
# Flash Embedded-Operation Status Reporter

This block models the status word that a NOR-style flash array returns while an internal operation is running. The host loads an address and a data byte with a chip-enable/write-enable strobe pair and then issues a command: single program, sector erase, suspend, resume, buffer load, buffer confirm or reset. While an operation runs, a read returns a status word instead of stored data. The word holds an inverted data bit, toggling bits, a time-limit bit, an erase indicator and a buffer-abort bit. Some modes return this word only for reads inside the affected sector.

The storage is a small word array that starts erased (all ones). Programming can only clear bits, so the new cell value is the old value ANDed with the programmed data. A program that needs a 0-to-1 change can never verify. It runs until its cycle limit and then reports a timeout. The cycle counters stand in for the internal operation time. Reads are registered and return one cycle after the request.

Top module: `flash_status_unit`

## Requirements
- R1: After reset every word reads 0xFF. A read request returns `rd_valid_o` with data one cycle later, and `rd_inv_o` is 0 in read-array mode.
- R2: A write strobe is active while `we_ni` and `ce_ni` are both low. The address is taken in the cycle where the second of the two goes low. The data is taken in the cycle where the first of them returns high.
- R3: After PROGRAM (cmd code 1), status reads return bit7 as the inverse of bit7 of the programmed data. Bit6 flips on every read. Bit5, bit3 and bit1 read 0, and bit2 keeps its value. Bits 4 and 0 always read 0.
- R4: A program that needs no 0-to-1 change completes after PROG_CYCLES cycles. The word then holds the old value AND the data, and reads return array data.
- R5: After ERASE (code 2) of the sector holding the latched address (sector = top SEC_W address bits), status reads give bit7=0, bit3=1, bit5=0 and a flipping bit6. Bit2 flips only on reads in the erased sector. After ERASE_CYCLES cycles of erasing, that sector reads 0xFF and other sectors are unchanged.
- R6: SUSPEND (code 3) during an erase gives erase-suspend. A read in the erased sector returns bit7=1, a held bit6, bit5=bit3=0 and a flipping bit2. Reads in other sectors return array data.
- R7: In erase-suspend, PROGRAM outside the suspended sector shows program status and then returns to erase-suspend. RESUME (code 4) finishes the erase.
- R8: SUSPEND during a program makes reads in the programmed sector return `rd_inv_o`=1 with data 0. Reads in other sectors return array data. RESUME finishes the program.
- R9: BUFFER LOAD (code 5) followed by strobes into one sector, then CONFIRM (code 6), programs all loaded words together. While busy, bit7 is the inverse of bit7 of the last loaded data and bit1=0.
- R10: A buffer strobe beyond BUF_DEPTH words, a strobe into a different sector, or a CONFIRM with no words loaded enters abort. In abort, bit1=1, bit5=0, and nothing is written.
- R11: A program needing a 0-to-1 change keeps bit5=0 until MAX_CYCLES cycles, then reads bit5=1. Timeout and abort persist until RESET (code 7) returns to read-array mode with the array untouched.
- R12: A command not valid in the current mode is ignored, including a PROGRAM into the suspended erase sector and a SUSPEND in read-array mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| we_ni | input | 1 | Write enable, active low |
| ce_ni | input | 1 | Chip enable, active low |
| wr_addr_i | input | ADDR_W | Strobe address bus |
| wr_data_i | input | 8 | Strobe data bus |
| cmd_valid_i | input | 1 | Command present this cycle |
| cmd_i | input | 3 | Command code |
| rd_en_i | input | 1 | Read request |
| rd_addr_i | input | ADDR_W | Read address |
| rd_data_o | output | 8 | Array data or status word |
| rd_valid_o | output | 1 | Read result valid |
| rd_inv_o | output | 1 | Read not allowed (program-suspended sector) |

## Verification
The bench builds the block with PROG_CYCLES=6, ERASE_CYCLES=24 and MAX_CYCLES=30. With these values, completions, timeouts and suspend windows arise within a few dozen cycles each. The bench can then read status twice inside a program window and still run many random programs and erases. BUF_DEPTH=4 and a 64-word array with four sectors keep the buffer overflow case and the cross-sector case cheap to reach.

// File: rtl/fsr_pkg.sv
package fsr_pkg;
  localparam int DW = 8;

  typedef enum logic [3:0] {
    ST_READ, ST_PROG, ST_ERASE, ST_ESUSP, ST_ESPROG,
    ST_PSUSP, ST_BLOAD, ST_BBUSY, ST_ABORT, ST_TMO
  } state_e;

  typedef enum logic [2:0] {
    CMD_NOP, CMD_PROG, CMD_ERASE, CMD_SUSP,
    CMD_RESUME, CMD_BLOAD, CMD_BGO, CMD_RESET
  } cmd_e;
endpackage

// File: rtl/fsr_strobe.sv
module fsr_strobe #(
  parameter int ADDR_W = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_ni,
  input  logic              ce_ni,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [7:0]        wr_data_i,
  output logic [ADDR_W-1:0] lat_addr_o,
  output logic [7:0]        lat_data_o,
  output logic              wr_stb_o
);
  logic act, act_q;
  assign act = ~we_ni & ~ce_ni;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q      <= 1'b0;
      lat_addr_o <= '0;
      lat_data_o <= '0;
      wr_stb_o   <= 1'b0;
    end else begin
      act_q    <= act;
      wr_stb_o <= 1'b0;
      if (act && !act_q) lat_addr_o <= wr_addr_i;  // later falling edge
      if (!act && act_q) begin                     // first rising edge
        lat_data_o <= wr_data_i;
        wr_stb_o   <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/fsr_array.sv
module fsr_array #(
  parameter int ADDR_W = 6,
  parameter int SEC_W  = 2,
  parameter int LANES  = 4
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic [ADDR_W-1:0]            rd_addr_i,
  output logic [7:0]                   rd_data_o,
  input  logic [ADDR_W-1:0]            chk_addr_i,
  output logic [7:0]                   chk_data_o,
  input  logic [LANES-1:0]             prg_en_i,
  input  logic [LANES-1:0][ADDR_W-1:0] prg_addr_i,
  input  logic [LANES-1:0][7:0]        prg_data_i,
  input  logic                         ers_en_i,
  input  logic [SEC_W-1:0]             ers_sec_i
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int OFS_W = ADDR_W - SEC_W;

  logic [7:0] mem [DEPTH];

  assign rd_data_o  = mem[rd_addr_i];
  assign chk_data_o = mem[chk_addr_i];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= 8'hFF;
    end else begin
      if (ers_en_i) begin
        for (int i = 0; i < DEPTH; i++)
          if (SEC_W'(i >> OFS_W) == ers_sec_i) mem[i] <= 8'hFF;
      end
      for (int l = 0; l < LANES; l++)
        if (prg_en_i[l]) mem[prg_addr_i[l]] <= mem[prg_addr_i[l]] & prg_data_i[l];
    end
  end
endmodule

// File: rtl/fsr_ctrl.sv
module fsr_ctrl
  import fsr_pkg::*;
#(
  parameter int ADDR_W       = 6,
  parameter int SEC_W        = 2,
  parameter int BUF_DEPTH    = 4,
  parameter int PROG_CYCLES  = 16,
  parameter int ERASE_CYCLES = 64,
  parameter int MAX_CYCLES   = 96
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic                             cmd_valid_i,
  input  cmd_e                             cmd_i,
  input  logic                             wr_stb_i,
  input  logic [ADDR_W-1:0]                lat_addr_i,
  input  logic [7:0]                       lat_data_i,
  input  logic [7:0]                       chk_data_i,
  output state_e                           state_o,
  output logic [SEC_W-1:0]                 esec_o,
  output logic [SEC_W-1:0]                 psec_o,
  output logic                             pbit7_o,
  output logic [BUF_DEPTH-1:0]             prg_en_o,
  output logic [BUF_DEPTH-1:0][ADDR_W-1:0] prg_addr_o,
  output logic [BUF_DEPTH-1:0][7:0]        prg_data_o,
  output logic                             ers_en_o,
  output logic [SEC_W-1:0]                 ers_sec_o
);
  localparam int CNT_W  = $clog2(MAX_CYCLES + 1);
  localparam int ECNT_W = $clog2(ERASE_CYCLES + 1);
  localparam int BC_W   = $clog2(BUF_DEPTH + 1);
  localparam int BI_W   = $clog2(BUF_DEPTH);

  state_e                             state_q;
  logic [SEC_W-1:0]                   esec_q, bsec_q;
  logic [ADDR_W-1:0]                  ptgt_q;
  logic [7:0]                         pdata_q;
  logic                               pfail_q;
  logic [CNT_W-1:0]                   pcnt_q;
  logic [ECNT_W-1:0]                  ecnt_q;
  logic [BC_W-1:0]                    bcnt_q;
  logic [BUF_DEPTH-1:0][ADDR_W-1:0]   baddr_q;
  logic [BUF_DEPTH-1:0][7:0]          bdata_q;

  logic [SEC_W-1:0] lat_sec;
  logic needs_set, p_busy, p_done, p_tmo, e_done, go;

  assign lat_sec   = lat_addr_i[ADDR_W-1 -: SEC_W];
  assign needs_set = (chk_data_i & lat_data_i) != lat_data_i;  // 0->1 cannot verify
  assign p_busy    = state_q inside {ST_PROG, ST_ESPROG, ST_BBUSY};
  assign p_done    = p_busy && !pfail_q && pcnt_q == CNT_W'(PROG_CYCLES - 1);
  assign p_tmo     = p_busy && pfail_q && pcnt_q == CNT_W'(MAX_CYCLES - 1);
  assign e_done    = state_q == ST_ERASE && ecnt_q == ECNT_W'(ERASE_CYCLES - 1);
  assign go        = cmd_valid_i;

  assign state_o   = state_q;
  assign esec_o    = esec_q;
  assign psec_o    = ptgt_q[ADDR_W-1 -: SEC_W];
  assign pbit7_o   = pdata_q[7];
  assign ers_en_o  = e_done;
  assign ers_sec_o = esec_q;

  always_comb begin
    for (int l = 0; l < BUF_DEPTH; l++) begin
      if (state_q == ST_BBUSY) begin
        prg_en_o[l]   = p_done && (BC_W'(l) < bcnt_q);
        prg_addr_o[l] = baddr_q[l];
        prg_data_o[l] = bdata_q[l];
      end else begin
        prg_en_o[l]   = p_done && (l == 0);
        prg_addr_o[l] = ptgt_q;
        prg_data_o[l] = pdata_q;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_READ;
      esec_q  <= '0;
      bsec_q  <= '0;
      ptgt_q  <= '0;
      pdata_q <= '0;
      pfail_q <= 1'b0;
      pcnt_q  <= '0;
      ecnt_q  <= '0;
      bcnt_q  <= '0;
      baddr_q <= '0;
      bdata_q <= '0;
    end else begin
      if (p_busy) pcnt_q <= pcnt_q + 1'b1;
      if (state_q == ST_ERASE) ecnt_q <= ecnt_q + 1'b1;
      unique case (state_q)
        ST_READ: if (go) begin
          if (cmd_i == CMD_PROG) begin
            state_q <= ST_PROG;
            ptgt_q  <= lat_addr_i;
            pdata_q <= lat_data_i;
            pfail_q <= needs_set;
            pcnt_q  <= '0;
          end else if (cmd_i == CMD_ERASE) begin
            state_q <= ST_ERASE;
            esec_q  <= lat_sec;
            ecnt_q  <= '0;
          end else if (cmd_i == CMD_BLOAD) begin
            state_q <= ST_BLOAD;
            bcnt_q  <= '0;
            pfail_q <= 1'b0;
          end
        end
        ST_PROG:
          if (p_done)                      state_q <= ST_READ;
          else if (p_tmo)                  state_q <= ST_TMO;
          else if (go && cmd_i == CMD_SUSP) state_q <= ST_PSUSP;
        ST_PSUSP:
          if (go && cmd_i == CMD_RESUME) state_q <= ST_PROG;
        ST_ERASE:
          if (e_done)                      state_q <= ST_READ;
          else if (go && cmd_i == CMD_SUSP) state_q <= ST_ESUSP;
        ST_ESUSP: if (go) begin
          if (cmd_i == CMD_RESUME) state_q <= ST_ERASE;
          else if (cmd_i == CMD_PROG && lat_sec != esec_q) begin
            state_q <= ST_ESPROG;
            ptgt_q  <= lat_addr_i;
            pdata_q <= lat_data_i;
            pfail_q <= needs_set;
            pcnt_q  <= '0;
          end
        end
        ST_ESPROG:
          if (p_done)     state_q <= ST_ESUSP;
          else if (p_tmo) state_q <= ST_TMO;
        ST_BLOAD:
          if (wr_stb_i) begin
            ptgt_q  <= lat_addr_i;
            pdata_q <= lat_data_i;
            if (bcnt_q == BC_W'(BUF_DEPTH) || (bcnt_q != '0 && lat_sec != bsec_q)) begin
              state_q <= ST_ABORT;
            end else begin
              baddr_q[bcnt_q[BI_W-1:0]] <= lat_addr_i;
              bdata_q[bcnt_q[BI_W-1:0]] <= lat_data_i;
              bcnt_q  <= bcnt_q + 1'b1;
              pfail_q <= pfail_q | needs_set;
              if (bcnt_q == '0) bsec_q <= lat_sec;
            end
          end else if (go && cmd_i == CMD_BGO) begin
            if (bcnt_q == '0) state_q <= ST_ABORT;
            else begin
              state_q <= ST_BBUSY;
              pcnt_q  <= '0;
            end
          end
        ST_BBUSY:
          if (p_done)     state_q <= ST_READ;
          else if (p_tmo) state_q <= ST_TMO;
        ST_ABORT, ST_TMO:
          if (go && cmd_i == CMD_RESET) state_q <= ST_READ;
        default: state_q <= ST_READ;
      endcase
    end
  end
endmodule

// File: rtl/fsr_status.sv
module fsr_status
  import fsr_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int SEC_W  = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  input  logic [7:0]        arr_data_i,
  input  state_e            state_i,
  input  logic [SEC_W-1:0]  esec_i,
  input  logic [SEC_W-1:0]  psec_i,
  input  logic              pbit7_i,
  output logic [7:0]        rd_data_o,
  output logic              rd_valid_o,
  output logic              rd_inv_o
);
  logic [SEC_W-1:0] rsec;
  logic [7:0] word;
  logic inv, st6, st2, t6_q, t2_q;

  assign rsec = rd_addr_i[ADDR_W-1 -: SEC_W];

  always_comb begin
    word = arr_data_i;
    inv  = 1'b0;
    st6  = 1'b0;
    st2  = 1'b0;
    unique case (state_i)
      ST_PROG, ST_ESPROG, ST_BBUSY, ST_TMO, ST_ABORT: begin
        word = {~pbit7_i, t6_q, state_i == ST_TMO, 2'b00, t2_q, state_i == ST_ABORT, 1'b0};
        st6  = 1'b1;
      end
      ST_ERASE: begin
        word = {1'b0, t6_q, 3'b001, t2_q, 2'b00};
        st6  = 1'b1;
        st2  = rsec == esec_i;
      end
      ST_ESUSP: if (rsec == esec_i) begin
        word = {1'b1, t6_q, 3'b000, t2_q, 2'b00};
        st2  = 1'b1;
      end
      ST_PSUSP: if (rsec == psec_i) begin
        word = '0;
        inv  = 1'b1;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_data_o  <= '0;
      rd_valid_o <= 1'b0;
      rd_inv_o   <= 1'b0;
      t6_q       <= 1'b0;
      t2_q       <= 1'b0;
    end else begin
      rd_valid_o <= rd_en_i;
      if (rd_en_i) begin
        rd_data_o <= word;
        rd_inv_o  <= inv;
        t6_q      <= t6_q ^ st6;
        t2_q      <= t2_q ^ st2;
      end
    end
  end
endmodule

// File: rtl/flash_status_unit.sv
module flash_status_unit
  import fsr_pkg::*;
#(
  parameter int ADDR_W       = 6,
  parameter int SEC_W        = 2,
  parameter int BUF_DEPTH    = 4,
  parameter int PROG_CYCLES  = 16,
  parameter int ERASE_CYCLES = 64,
  parameter int MAX_CYCLES   = 96
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_ni,
  input  logic              ce_ni,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [7:0]        wr_data_i,
  input  logic              cmd_valid_i,
  input  logic [2:0]        cmd_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [7:0]        rd_data_o,
  output logic              rd_valid_o,
  output logic              rd_inv_o
);
  logic [ADDR_W-1:0] lat_addr;
  logic [7:0] lat_data, arr_data, chk_data;
  logic wr_stb, pbit7, ers_en;
  state_e state;
  logic [SEC_W-1:0] esec, psec, ers_sec;
  logic [BUF_DEPTH-1:0] prg_en;
  logic [BUF_DEPTH-1:0][ADDR_W-1:0] prg_addr;
  logic [BUF_DEPTH-1:0][7:0] prg_data;

  fsr_strobe #(.ADDR_W(ADDR_W)) u_strobe (
    .clk_i, .rst_ni, .we_ni, .ce_ni, .wr_addr_i, .wr_data_i,
    .lat_addr_o(lat_addr), .lat_data_o(lat_data), .wr_stb_o(wr_stb)
  );

  fsr_array #(.ADDR_W(ADDR_W), .SEC_W(SEC_W), .LANES(BUF_DEPTH)) u_array (
    .clk_i, .rst_ni,
    .rd_addr_i(rd_addr_i), .rd_data_o(arr_data),
    .chk_addr_i(lat_addr), .chk_data_o(chk_data),
    .prg_en_i(prg_en), .prg_addr_i(prg_addr), .prg_data_i(prg_data),
    .ers_en_i(ers_en), .ers_sec_i(ers_sec)
  );

  fsr_ctrl #(
    .ADDR_W(ADDR_W), .SEC_W(SEC_W), .BUF_DEPTH(BUF_DEPTH),
    .PROG_CYCLES(PROG_CYCLES), .ERASE_CYCLES(ERASE_CYCLES), .MAX_CYCLES(MAX_CYCLES)
  ) u_ctrl (
    .clk_i, .rst_ni, .cmd_valid_i, .cmd_i(cmd_e'(cmd_i)),
    .wr_stb_i(wr_stb), .lat_addr_i(lat_addr), .lat_data_i(lat_data), .chk_data_i(chk_data),
    .state_o(state), .esec_o(esec), .psec_o(psec), .pbit7_o(pbit7),
    .prg_en_o(prg_en), .prg_addr_o(prg_addr), .prg_data_o(prg_data),
    .ers_en_o(ers_en), .ers_sec_o(ers_sec)
  );

  fsr_status #(.ADDR_W(ADDR_W), .SEC_W(SEC_W)) u_status (
    .clk_i, .rst_ni, .rd_en_i, .rd_addr_i, .arr_data_i(arr_data),
    .state_i(state), .esec_i(esec), .psec_i(psec), .pbit7_i(pbit7),
    .rd_data_o, .rd_valid_o, .rd_inv_o
  );
endmodule

// File: rtl/fsr_checker.sv
module fsr_checker
  import fsr_pkg::*;
(
  input logic       clk_i,
  input logic       rst_ni,
  input logic       rd_en_i,
  input logic [7:0] rd_data_o,
  input logic       rd_inv_o,
  input logic       cmd_valid_i,
  input logic [2:0] cmd_i,
  input state_e     state_i
);
  AST_ERASE_WORD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && state_i == ST_ERASE) |=> (rd_data_o[3] && !rd_data_o[7] && !rd_data_o[5] && !rd_data_o[1])); // R5

  AST_INV_SCOPE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && state_i != ST_PSUSP) |=> !rd_inv_o); // R8

  AST_TMO_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == ST_TMO && !(cmd_valid_i && cmd_i == 3'd7)) |=> state_i == ST_TMO); // R11

  AST_TMO_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && state_i == ST_TMO) |=> rd_data_o[5]); // R11

  AST_ABORT_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && state_i == ST_ABORT) |=> (rd_data_o[1] && !rd_data_o[5])); // R10

  AST_PROG_IN_LIMIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && state_i inside {ST_PROG, ST_ESPROG, ST_BBUSY}) |=> (!rd_data_o[5] && !rd_data_o[1] && !rd_data_o[3])); // R3
endmodule

bind flash_status_unit fsr_checker u_chk (
  .clk_i, .rst_ni, .rd_en_i, .rd_data_o, .rd_inv_o, .cmd_valid_i, .cmd_i,
  .state_i(state)
);

// File: tb/flash_status_unit_bench.sv
module flash_status_unit_bench;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 6;
  localparam int PC = 6;
  localparam int EC = 24;
  localparam int MC = 30;

  logic clk = 1'b0, rst_n = 1'b0;
  logic we_n = 1'b1, ce_n = 1'b1;
  logic [AW-1:0] wr_addr = '0, rd_addr = '0;
  logic [7:0] wr_data = '0;
  logic cmd_valid = 1'b0, rd_en = 1'b0;
  logic [2:0] cmd = '0;
  logic [7:0] rd_data;
  logic rd_valid, rd_inv;

  int total = 0, errs = 0;
  bit finished = 0;
  logic [7:0] model [64];

  always #(CLK_PERIOD/2) clk = ~clk;

  flash_status_unit #(.ADDR_W(AW), .SEC_W(2), .BUF_DEPTH(4),
    .PROG_CYCLES(PC), .ERASE_CYCLES(EC), .MAX_CYCLES(MC)) u_flash_status_unit (
    .clk_i(clk), .rst_ni(rst_n), .we_ni(we_n), .ce_ni(ce_n),
    .wr_addr_i(wr_addr), .wr_data_i(wr_data), .cmd_valid_i(cmd_valid), .cmd_i(cmd),
    .rd_en_i(rd_en), .rd_addr_i(rd_addr), .rd_data_o(rd_data),
    .rd_valid_o(rd_valid), .rd_inv_o(rd_inv)
  );

  function automatic logic [7:0] prog_word(logic [7:0] d);
    return {~d[7], 7'b0};
  endfunction

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    total++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wcyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic strobe(logic [AW-1:0] a, logic [7:0] d);
    @(negedge clk) ce_n = 1'b0; wr_addr = ~a;
    @(negedge clk) we_n = 1'b0; wr_addr = a;
    @(negedge clk) wr_addr = ~a; wr_data = d;
    @(negedge clk) ce_n = 1'b1;
    @(negedge clk) we_n = 1'b1; wr_data = ~d;
    @(negedge clk);
  endtask

  task automatic command(logic [2:0] c);
    @(negedge clk) cmd_valid = 1'b1; cmd = c;
    @(negedge clk) cmd_valid = 1'b0; cmd = 3'd0;
  endtask

  task automatic rd(logic [AW-1:0] a, output logic [7:0] d, output logic inv);
    rd_en = 1'b1; rd_addr = a;
    @(negedge clk) rd_en = 1'b0;
    d = rd_data; inv = rd_inv;
  endtask

  task automatic do_prog(logic [AW-1:0] a, logic [7:0] d);
    strobe(a, d);
    command(3'd1);
    model[a] = model[a] & d;
  endtask

  task automatic model_erase(logic [1:0] s);
    for (int i = 0; i < 64; i++) if (i[5:4] == s) model[i] = 8'hFF;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errs++;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", total, errs);
      $finish;
    end
  end

  initial begin
    logic [7:0] d, d2;
    logic inv, inv2;
    void'($urandom(32'h5EED_1234));
    for (int i = 0; i < 64; i++) model[i] = 8'hFF;
    wcyc(3);
    rst_n = 1'b1;
    wcyc(2);

    // R1 reset state and read latency
    rd_en = 1'b1; rd_addr = 6'd0;
    @(negedge clk) rd_en = 1'b0;
    check("R1 valid", {7'b0, rd_valid}, 8'h01);
    check("R1 data", rd_data, 8'hFF);
    check("R1 inv", {7'b0, rd_inv}, 8'h00);

    // R12 suspend in read mode ignored
    command(3'd3);
    rd(6'd1, d, inv);
    check("R12 suspend ignored", d, 8'hFF);

    // R3 program status, R2 capture
    do_prog(6'd5, 8'h35);
    rd(6'd5, d, inv);
    rd(6'd9, d2, inv2);
    check("R3 word", d & 8'hBB, prog_word(8'h35));
    check("R3 bit6 flips", {7'b0, d[6] ^ d2[6]}, 8'h01);
    check("R3 bit2 held", {7'b0, d[2] ^ d2[2]}, 8'h00);
    wcyc(PC + 3);
    rd(6'd5, d, inv);
    check("R4 R2 programmed", d, 8'h35);
    rd(6'd6, d, inv);
    check("R2 neighbour untouched", d, 8'hFF);

    do_prog(6'h12, 8'hA5);
    wcyc(PC + 3);
    rd(6'h12, d, inv);
    check("R4 second word", d, 8'hA5);

    // R5 erase sector 0
    strobe(6'd3, 8'h00);
    command(3'd2);
    rd(6'd5, d, inv);
    rd(6'd5, d2, inv2);
    check("R5 word", d & 8'hBB, 8'h08);
    check("R5 bit2 flips in sector", {7'b0, d[2] ^ d2[2]}, 8'h01);
    check("R5 bit6 flips", {7'b0, d[6] ^ d2[6]}, 8'h01);
    rd(6'h22, d, inv);
    rd(6'h22, d2, inv2);
    check("R5 bit2 held elsewhere", {7'b0, d[2] ^ d2[2]}, 8'h00);

    // R6 erase suspend
    command(3'd3);
    rd(6'd5, d, inv);
    rd(6'd5, d2, inv2);
    check("R6 word", d & 8'hBB, 8'h80);
    check("R6 bit6 held", {7'b0, d[6] ^ d2[6]}, 8'h00);
    check("R6 bit2 flips", {7'b0, d[2] ^ d2[2]}, 8'h01);
    rd(6'h12, d, inv);
    check("R6 other sector data", d, 8'hA5);

    // R12 program into suspended sector ignored
    strobe(6'd7, 8'h00);
    command(3'd1);
    rd(6'd7, d, inv);
    check("R12 suspended sector program ignored", d & 8'hBB, 8'h80);

    // R7 program during erase suspend
    strobe(6'h21, 8'h85);
    command(3'd1);
    model[6'h21] = 8'h85;
    rd(6'h21, d, inv);
    check("R7 program status", d & 8'hBB, prog_word(8'h85));
    wcyc(PC + 3);
    rd(6'h21, d, inv);
    check("R7 programmed", d, 8'h85);
    rd(6'd5, d, inv);
    check("R7 back in suspend", d & 8'hBB, 8'h80);
    command(3'd4);
    wcyc(EC + 3);
    model_erase(2'd0);
    rd(6'd5, d, inv);
    check("R5 R7 sector erased", d, 8'hFF);
    rd(6'h12, d, inv);
    check("R5 other sector kept", d, 8'hA5);
    model[6'h12] = 8'hA5;

    // R8 program suspend
    do_prog(6'h30, 8'h3C);
    command(3'd3);
    rd(6'h31, d, inv);
    check("R8 inv in sector", {7'b0, inv}, 8'h01);
    rd(6'h12, d, inv);
    check("R8 other sector data", d, 8'hA5);
    check("R8 other sector valid", {7'b0, inv}, 8'h00);
    command(3'd4);
    wcyc(PC + 3);
    rd(6'h30, d, inv);
    check("R8 resumed and done", d, 8'h3C);

    // R9 buffer program
    command(3'd5);
    strobe(6'h08, 8'h11);
    strobe(6'h09, 8'h92);
    command(3'd6);
    model[6'h08] = 8'h11; model[6'h09] = 8'h92;
    rd(6'h08, d, inv);
    check("R9 busy word", d & 8'hBB, prog_word(8'h92));
    wcyc(PC + 3);
    rd(6'h08, d, inv);
    check("R9 first word", d, 8'h11);
    rd(6'h09, d, inv);
    check("R9 last word", d, 8'h92);

    // R10 abort: cross sector
    command(3'd5);
    strobe(6'h0A, 8'h2B);
    strobe(6'h1A, 8'h44);
    rd(6'h0A, d, inv);
    check("R10 cross-sector abort", d & 8'h22, 8'h02);
    wcyc(MC + 5);
    rd(6'h0A, d, inv);
    check("R11 abort persists", d & 8'h22, 8'h02);
    command(3'd7);
    rd(6'h0A, d, inv);
    check("R10 nothing written", d, 8'hFF);

    // R10 abort: no words loaded
    command(3'd5);
    command(3'd6);
    rd(6'h00, d, inv);
    check("R10 empty confirm abort", d & 8'h22, 8'h02);
    command(3'd7);

    // R10 abort: overflow
    command(3'd5);
    for (int k = 0; k < 5; k++) strobe(6'h2C + 6'(k), 8'h00);
    rd(6'h2C, d, inv);
    check("R10 overflow abort", d & 8'h22, 8'h02);
    command(3'd7);
    rd(6'h2C, d, inv);
    check("R10 overflow nothing written", d, 8'hFF);

    // R11 timeout: 0x11 -> 0x33 needs set bits
    strobe(6'h08, 8'h33);
    command(3'd1);
    rd(6'h08, d, inv);
    check("R11 within limit", d & 8'hBB, prog_word(8'h33));
    wcyc(MC + 3);
    rd(6'h08, d, inv);
    check("R11 timeout word", d & 8'hBB, 8'hA0);
    wcyc(20);
    rd(6'h08, d, inv);
    check("R11 timeout sticky", d & 8'h20, 8'h20);
    command(3'd7);
    rd(6'h08, d, inv);
    check("R11 reset keeps data", d, 8'h11);

    // R4 R5 constrained random programs and erases
    for (int it = 0; it < 40; it++) begin
      logic [AW-1:0] a;
      logic [7:0] v;
      a = AW'($urandom_range(63));
      if (it % 9 == 8) begin
        strobe(a, 8'h00);
        command(3'd2);
        model_erase(a[5:4]);
        wcyc(EC + 3);
      end else begin
        v = model[a] & 8'($urandom);
        do_prog(a, v);
        wcyc(PC + 3);
      end
      rd(a, d, inv);
      check("R4 random target", d, model[a]);
      for (int j = 0; j < 3; j++) begin
        logic [AW-1:0] b;
        b = AW'($urandom_range(63));
        rd(b, d, inv);
        check("R5 random probe", d, model[b]);
      end
    end

    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", total, errs);
    $finish;
  end
endmodule